// File: doc/BRIEF.md
# Multifunction ALU with Barrel Shifter

This block is the purely combinational arithmetic/logic unit of a small 32-bit RISC-style datapath. It takes two operands `x` and `y`. Its control is split into four fields: a class selector, an add/subtract bit, a logic code, and a shift code with an amount-source select and a constant amount. From these it produces a 32-bit result, a signed-overflow flag and a zero flag. The decode stage of the host pipeline drives the control fields. The result feeds writeback or an address path, and the zero flag feeds branch resolution.

Internally there are four pieces:
- an adder/subtractor that builds subtraction by inverting `y` and injecting a carry of one;
- a signed compare path that reuses the adder's difference;
- a two-bit-coded bitwise logic unit;
- a log-depth barrel shifter that operates on `y`.

The shift amount comes either from a constant field or from the low bits of `x`.

Top module: `alu_core`

## Requirements
- R1: `fclass_i` picks the result source: 2'b00 shifter, 2'b01 signed compare, 2'b10 adder/subtractor, 2'b11 logic unit.
- R2: In the adder class, `sub_i`=0 gives `x+y` and `sub_i`=1 gives `x-y` (computed as `x + ~y + 1`), both modulo 2^32.
- R3: `ovfl_o` is 1 exactly when the adder class is selected and the signed (two's complement) sum or difference does not fit in 32 bits. It is derived from the carries into and out of bit 31. In every other class it is 0.
- R4: In the compare class with `sub_i`=1, `result_o` is 32'h1 when signed `x` < signed `y`, and 32'h0 otherwise. This includes the cases where the subtraction overflows. Bits 31:1 are always 0 in this class.
- R5: `logic_fn_i` selects 2'b00 AND, 2'b01 OR, 2'b10 XOR, 2'b11 NOR of `x` and `y`.
- R6: `shift_fn_i` selects 2'b00 pass `y` unshifted, 2'b01 logical left, and 2'b10 logical right. Logical shifts fill the vacated bits with zeros.
- R7: `shift_fn_i`=2'b11 shifts `y` right arithmetically, filling the vacated bits with copies of `y[31]`.
- R8: `amt_var_i`=0 takes the shift amount from `amt_const_i`. `amt_var_i`=1 takes it from `x_i[4:0]`, and the other source is then ignored.
- R9: Every amount from 0 to 31 shifts by exactly that many bit positions. The shifter is built from five cascaded stages of 1, 2, 4, 8 and 16 bits, each enabled by one amount bit.
- R10: `zero_o` is 1 exactly when all 32 bits of `result_o` are 0, in every class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_i | input | 32 | First operand; low 5 bits are the variable shift amount |
| y_i | input | 32 | Second operand; the value that is shifted |
| fclass_i | input | 2 | Function class selector |
| sub_i | input | 1 | 1 = subtract, 0 = add |
| logic_fn_i | input | 2 | Bitwise function code |
| shift_fn_i | input | 2 | Shift kind code |
| amt_var_i | input | 1 | 1 = amount from x_i[4:0], 0 = from amt_const_i |
| amt_const_i | input | 5 | Constant shift amount |
| result_o | output | 32 | Selected result |
| ovfl_o | output | 1 | Signed overflow of the adder class |
| zero_o | output | 1 | All result bits zero |

## Verification
The bench drives pairs drawn from 0, all ones, 32'h80000000, 32'h7FFFFFFF and 1 through every class and code, then adds random operands. Comparing the signed extremes catches a compare that uses only the raw difference sign: it would report 32'h7FFFFFFF < 32'h80000000 because the subtraction overflowed. An overflow flag built from the sum sign alone fails on 32'h80000000 + 32'h80000000. Amounts of 0, 31 and every single stage are swept with both amount sources. A miswired stage then shows up as a wrong shift distance, and an arithmetic shift that fills with zeros shows up on 32'h80000000. The zero flag is checked for all-zero logic and arithmetic results.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    FC_SHIFT = 2'b00,
    FC_SLT   = 2'b01,
    FC_ARITH = 2'b10,
    FC_LOGIC = 2'b11
  } fclass_e;

  typedef enum logic [1:0] {
    LG_AND = 2'b00,
    LG_OR  = 2'b01,
    LG_XOR = 2'b10,
    LG_NOR = 2'b11
  } logic_fn_e;

  typedef enum logic [1:0] {
    SH_NONE = 2'b00,
    SH_LSL  = 2'b01,
    SH_LSR  = 2'b10,
    SH_ASR  = 2'b11
  } shift_fn_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         c_msb_in_o,
  output logic         c_out_o
);
  logic [W-1:0] b_eff;
  logic [W-1:0] low_sum;

  assign b_eff = sub_i ? ~b_i : b_i;

  // split at the msb so both carries around it are visible
  assign low_sum = {1'b0, a_i[W-2:0]} + {1'b0, b_eff[W-2:0]} + {{(W-1){1'b0}}, sub_i};
  assign c_msb_in_o = low_sum[W-1];
  assign {c_out_o, sum_o[W-1]} = {1'b0, a_i[W-1]} + {1'b0, b_eff[W-1]} + {1'b0, c_msb_in_o};
  assign sum_o[W-2:0] = low_sum[W-2:0];
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   fn_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (logic_fn_e'(fn_i))
      LG_AND:  res_o = a_i & b_i;
      LG_OR:   res_o = a_i | b_i;
      LG_XOR:  res_o = a_i ^ b_i;
      default: res_o = ~(a_i | b_i);
    endcase
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
  import alu_pkg::*;
#(
  parameter int W   = 32,
  parameter int AMW = $clog2(W)
) (
  input  logic [W-1:0]   data_i,
  input  logic [AMW-1:0] amt_i,
  input  logic [1:0]     fn_i,
  output logic [W-1:0]   data_o
);
  logic [AMW:0][W-1:0] stage;
  shift_fn_e fn;

  assign fn = shift_fn_e'(fn_i);
  assign stage[0] = data_i;

  for (genvar k = 0; k < AMW; k++) begin : g_stage
    localparam int D = 1 << k;
    logic [W-1:0] lsl, lsr, asr;
    assign lsl = {stage[k][W-1-D:0], {D{1'b0}}};
    assign lsr = {{D{1'b0}}, stage[k][W-1:D]};
    assign asr = {{D{stage[k][W-1]}}, stage[k][W-1:D]};
    always_comb begin
      if (!amt_i[k]) stage[k+1] = stage[k];
      else begin
        unique case (fn)
          SH_LSL:  stage[k+1] = lsl;
          SH_LSR:  stage[k+1] = lsr;
          SH_ASR:  stage[k+1] = asr;
          default: stage[k+1] = stage[k];
        endcase
      end
    end
  end

  assign data_o = stage[AMW];
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int W   = 32,
  parameter int AMW = $clog2(W)
) (
  input  logic [W-1:0]   x_i,
  input  logic [W-1:0]   y_i,
  input  logic [1:0]     fclass_i,
  input  logic           sub_i,
  input  logic [1:0]     logic_fn_i,
  input  logic [1:0]     shift_fn_i,
  input  logic           amt_var_i,
  input  logic [AMW-1:0] amt_const_i,
  output logic [W-1:0]   result_o,
  output logic           ovfl_o,
  output logic           zero_o
);
  logic [W-1:0]   sum, lg_res, sh_res, slt_res;
  logic           c_msb_in, c_out, add_ovf;
  logic [AMW-1:0] amt;

  alu_addsub #(.W(W)) u_addsub (
    .a_i(x_i), .b_i(y_i), .sub_i(sub_i),
    .sum_o(sum), .c_msb_in_o(c_msb_in), .c_out_o(c_out)
  );

  alu_logic #(.W(W)) u_logic (
    .a_i(x_i), .b_i(y_i), .fn_i(logic_fn_i), .res_o(lg_res)
  );

  assign amt = amt_var_i ? x_i[AMW-1:0] : amt_const_i;

  alu_shifter #(.W(W), .AMW(AMW)) u_shift (
    .data_i(y_i), .amt_i(amt), .fn_i(shift_fn_i), .data_o(sh_res)
  );

  assign add_ovf = c_msb_in ^ c_out;
  // true sign of x-y even when the difference wraps
  assign slt_res = {{(W-1){1'b0}}, sum[W-1] ^ add_ovf};

  always_comb begin
    unique case (fclass_e'(fclass_i))
      FC_SHIFT: result_o = sh_res;
      FC_SLT:   result_o = slt_res;
      FC_ARITH: result_o = sum;
      default:  result_o = lg_res;
    endcase
  end

  assign ovfl_o = (fclass_e'(fclass_i) == FC_ARITH) && add_ovf;
  assign zero_o = ~|result_o;
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] x_i,
  input logic [W-1:0] y_i,
  input logic [1:0]   fclass_i,
  input logic         sub_i,
  input logic [1:0]   logic_fn_i,
  input logic [1:0]   shift_fn_i,
  input logic [W-1:0] result_o,
  input logic         ovfl_o,
  input logic         zero_o
);
  logic y_neg;
  assign y_neg = sub_i ? ~y_i[W-1] : y_i[W-1];

  always_comb begin
    if (fclass_i == 2'b01)
      AST_SLT_UPPER_ZERO: assert (result_o[W-1:1] == '0); // R4
    if (ovfl_o)
      AST_OVFL_SIGNS: assert (fclass_i == 2'b10 && x_i[W-1] == y_neg && result_o[W-1] != x_i[W-1]); // R3
    if (fclass_i == 2'b00 && shift_fn_i == 2'b00)
      AST_NO_SHIFT_PASS: assert (result_o == y_i); // R6
    if (fclass_i == 2'b00 && shift_fn_i == 2'b11)
      AST_ASR_SIGN_KEPT: assert (result_o[W-1] == y_i[W-1]); // R7
    if (fclass_i == 2'b11 && logic_fn_i == 2'b00)
      AST_AND_RESULT: assert (result_o == (x_i & y_i)); // R5
    if (zero_o)
      AST_ZERO_NO_SLT_ONE: assert (!(fclass_i == 2'b01 && result_o[0])); // R10
  end
endmodule

bind alu_core alu_core_chk #(.W(W)) u_chk (
  .x_i(x_i), .y_i(y_i), .fclass_i(fclass_i), .sub_i(sub_i),
  .logic_fn_i(logic_fn_i), .shift_fn_i(shift_fn_i),
  .result_o(result_o), .ovfl_o(ovfl_o), .zero_o(zero_o)
);

// File: tb/tb_alu_core.sv
module tb_alu_core;
  logic        clk = 1'b0;
  logic [31:0] x = '0, y = '0;
  logic [1:0]  fclass = '0, lfn = '0, sfn = '0;
  logic        sub = 1'b0, avar = 1'b0;
  logic [4:0]  acon = '0;
  logic [31:0] result;
  logic        ovfl, zero;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  alu_core dut (
    .x_i(x), .y_i(y), .fclass_i(fclass), .sub_i(sub), .logic_fn_i(lfn),
    .shift_fn_i(sfn), .amt_var_i(avar), .amt_const_i(acon),
    .result_o(result), .ovfl_o(ovfl), .zero_o(zero)
  );

  logic [31:0] corner [5] = '{32'h0, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF, 32'h1};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h (x=%h y=%h cls=%0d)", tag, act, exp, x, y, fclass);
    end
  endtask

  // behavioural reference for current inputs, then compare after settle
  task automatic apply_and_check();
    logic [31:0] er;
    logic        eo;
    longint      sx, sy, r;
    int          amt;
    string       tag;
    @(posedge clk);
    @(negedge clk);
    sx  = longint'($signed(x));
    sy  = longint'($signed(y));
    amt = avar ? int'(x[4:0]) : int'(acon);
    eo  = 1'b0;
    case (fclass)
      2'b00: begin
        case (sfn)
          2'b00: er = y;
          2'b01: er = y << amt;
          2'b10: er = y >> amt;
          default: er = $signed(y) >>> amt;
        endcase
        tag = (sfn == 2'b11) ? "R7 asr" : (avar ? "R8 var amount" : "R6 R9 shift");
      end
      2'b01: begin
        er  = (sx < sy) ? 32'h1 : 32'h0;
        tag = "R4 slt";
      end
      2'b10: begin
        r   = sub ? sx - sy : sx + sy;
        er  = r[31:0];
        eo  = (r > 64'sd2147483647) || (r < -64'sd2147483648);
        tag = "R2 addsub";
      end
      default: begin
        case (lfn)
          2'b00: er = x & y;
          2'b01: er = x | y;
          2'b10: er = x ^ y;
          default: er = ~(x | y);
        endcase
        tag = "R5 logic";
      end
    endcase
    chk({tag, " R1 result"}, result, er);
    chk("R3 ovfl", {31'b0, ovfl}, {31'b0, eo});
    chk("R10 zero", {31'b0, zero}, {31'b0, er == 32'h0});
  endtask

  initial begin
    // idle inputs: shift class, pass of zero
    #1;
    chk("R10 zero at idle", {31'b0, zero}, 32'h1);
    chk("R1 idle result", result, 32'h0);

    foreach (corner[i]) foreach (corner[j]) begin
      x = corner[i]; y = corner[j];
      fclass = 2'b10; sub = 1'b0; apply_and_check();
      sub = 1'b1; apply_and_check();
      fclass = 2'b01; apply_and_check();
      fclass = 2'b11;
      for (int f = 0; f < 4; f++) begin lfn = f[1:0]; apply_and_check(); end
    end

    // every amount and every shift kind, both sources
    fclass = 2'b00;
    for (int a = 0; a < 32; a++) begin
      for (int f = 0; f < 4; f++) begin
        sfn = f[1:0];
        y = 32'h8000_0001; x = 32'hABCD_EF00; avar = 1'b0; acon = a[4:0];
        apply_and_check();
        y = 32'h5A5A_C3C3; x = {27'h7FF_FFFF, a[4:0]}; avar = 1'b1; acon = ~a[4:0];
        apply_and_check();
      end
    end

    for (int n = 0; n < 400; n++) begin
      x = $urandom; y = $urandom;
      fclass = 2'($urandom); sub = (fclass == 2'b01) ? 1'b1 : 1'($urandom);
      lfn = 2'($urandom); sfn = 2'($urandom);
      avar = 1'($urandom); acon = 5'($urandom);
      apply_and_check();
    end

    // targeted overflow cases
    fclass = 2'b10; sub = 1'b0; x = 32'h8000_0000; y = 32'h8000_0000;
    apply_and_check(); // R3 negative overflow to zero
    sub = 1'b1; x = 32'h7FFF_FFFF; y = 32'hFFFF_FFFF;
    apply_and_check(); // R3 positive overflow on subtract
    fclass = 2'b01; x = 32'h7FFF_FFFF; y = 32'h8000_0000;
    apply_and_check(); // R4 compare across overflow

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule